// File: doc/BRIEF.md
# Setup-Table Destination Address Filter

This block decides whether an incoming frame is meant for this station. Software loads a match table by sending a 128-byte setup frame as a byte stream. The frame is a 16-row by 8-column byte array, so it carries up to fourteen 48-bit station addresses. The length of the setup frame also carries a small command. When the frame is longer than 128 bytes, the excess selects all-multicast and promiscuous operation. When loading finishes, the block gives a one-cycle acknowledge pulse.

On the receive side, the block takes the destination bytes at the start of each frame. As soon as the sixth destination byte arrives, it compares the whole address against every table entry in parallel. One cycle later it reports accept or reject, together with a valid strobe. The broadcast address gets no special treatment: it passes only when the table holds it.

Top module: `dest_filter`

## Requirements
- R1: Setup byte number i (first byte is i = 0) sits at row i/8 and column i%8. Rows 0–7 form half 0 and rows 8–15 form half 1. Row r of a half (r = i/8 mod 8) gives address byte r, where byte 0 is the first destination byte on the wire. Column c in 1..7 of half h loads table entry h*7 + c - 1.
- R2: A setup frame whose total length L is at least 128 bytes raises `su_ack` for exactly one cycle, in the cycle after its last byte is accepted. From then on the table takes part in matching.
- R3: L = 128 clears both modes. L = 128 + c sets all-multicast from bit 0 of c and promiscuous from bit 1 of c. A setup frame shorter than 128 bytes gives no acknowledge and leaves both modes unchanged. Modes never change except with an acknowledge.
- R4: `dec_valid` pulses for one cycle, in the cycle after the sixth destination byte is accepted. Later bytes of the same frame produce no further decision. `rx_sof` restarts address capture at byte 0.
- R5: A destination that equals any loaded entry is accepted. A destination that differs from every entry, even in a single byte, is rejected.
- R6: The broadcast address (all bytes 0xFF) is accepted only when a table entry holds it.
- R7: In all-multicast mode, any destination whose first byte has bit 0 set is accepted. With the mode off, such a destination follows the table.
- R8: In promiscuous mode, every frame is accepted.
- R9: After reset, `su_ack`, `dec_valid` and `dec_accept` are low, no entry is active and both modes are off, so every frame is rejected.
- R10: Bytes in column 0, and bytes in rows 6, 7, 14 and 15, load nothing. An address built from them is not matched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| su_valid | input | 1 | Setup byte present |
| su_data | input | 8 | Setup byte |
| su_last | input | 1 | Marks the final setup byte |
| su_ack | output | 1 | One-cycle setup completion pulse |
| rx_valid | input | 1 | Receive byte present |
| rx_sof | input | 1 | Marks the first byte of a received frame |
| rx_data | input | 8 | Receive byte |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Accept (1) or reject (0), qualified by dec_valid |

## Verification
The hardest case to reach is a table slot sitting at a seam of the two-half layout. Examples are the last column of half 0, the first column of half 1, and the junk bytes in column 0 and rows 6–7. Reaching these takes a complete, well-formed 128-byte setup frame, which the bench builds from the R1 formula rather than from a list. It then probes addresses taken from those seams, and an address assembled from the column-0 junk. Mode persistence across a too-short setup frame is reached by loading a mode and then sending a truncated frame before probing again.

// File: rtl/fd_pkg.sv
package fd_pkg;
  localparam int SU_ROWS    = 16;
  localparam int SU_COLS    = 8;
  localparam int HALF_ROWS  = 8;
  localparam int ADDR_BYTES = 6;
  localparam int AW         = 8 * ADDR_BYTES;
  localparam int BASE_LEN   = SU_ROWS * SU_COLS;
  localparam int NUM_ENT    = (SU_ROWS / HALF_ROWS) * (SU_COLS - 1);
  localparam int ENT_W      = $clog2(NUM_ENT);
  localparam int COL_W      = $clog2(SU_COLS);
  localparam int ROW_W      = $clog2(SU_ROWS);
  localparam int HROW_W     = $clog2(HALF_ROWS);
  localparam int POS_W      = $clog2(BASE_LEN);
  localparam int CNT_W      = POS_W + 1;
  localparam int IDX_W      = $clog2(ADDR_BYTES + 1);

  typedef struct packed {
    logic              hit;
    logic [ENT_W-1:0]  entry;
    logic [HROW_W-1:0] byte_k;
  } slot_t;

  typedef struct packed {
    logic promisc;
    logic allmulti;
  } mode_t;

  // Where a byte of the setup array lands in the table.
  function automatic slot_t map_setup_byte(input logic [POS_W-1:0] pos);
    slot_t s;
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  row;
    logic [HROW_W-1:0] k;
    col      = pos[COL_W-1:0];
    row      = pos[POS_W-1:COL_W];
    k        = row[HROW_W-1:0];
    s.hit    = (col != '0) && (k < HROW_W'(ADDR_BYTES));
    s.entry  = ENT_W'(int'(row[ROW_W-1]) * (SU_COLS - 1) + int'(col) - 1);
    s.byte_k = k;
    return s;
  endfunction

  // Mode bits come from the setup length beyond the base array size.
  function automatic mode_t mode_from_len(input logic [CNT_W-1:0] len);
    logic [CNT_W-1:0] extra;
    mode_t m;
    extra      = len - CNT_W'(BASE_LEN);
    m.allmulti = extra[0];
    m.promisc  = extra[1];
    return m;
  endfunction

  // Group (multicast) bit of the first destination byte.
  function automatic logic is_group(input logic [7:0] first_byte);
    return first_byte[0];
  endfunction
endpackage

// File: rtl/fd_setup_loader.sv
module fd_setup_loader
  import fd_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          su_valid,
  input  logic [7:0]                    su_data,
  input  logic                          su_last,
  output logic [NUM_ENT-1:0][AW-1:0]    tbl_o,
  output logic                          tbl_active_o,
  output mode_t                         mode_o,
  output logic                          su_ack_o
);
  localparam logic [CNT_W-1:0] BASE_C = CNT_W'(BASE_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_now;
  logic             in_body;
  logic             wr_en;
  logic             done;
  slot_t            slot;

  assign len_now = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
  assign in_body = cnt_q < BASE_C;
  assign slot    = map_setup_byte(cnt_q[POS_W-1:0]);
  assign wr_en   = su_valid && in_body && slot.hit;
  assign done    = su_valid && su_last && (len_now >= BASE_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      tbl_active_o <= 1'b0;
      mode_o       <= '0;
      su_ack_o     <= 1'b0;
    end else begin
      su_ack_o <= done;
      if (su_valid) begin
        cnt_q <= su_last ? '0 : len_now;
      end
      if (done) begin
        tbl_active_o <= 1'b1;
        mode_o       <= mode_from_len(len_now);
      end
    end
  end

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    logic [AW-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else begin
        for (int k = 0; k < ADDR_BYTES; k++) begin
          if (wr_en && slot.entry == ENT_W'(e) && slot.byte_k == HROW_W'(k))
            ent_q[AW-1-8*k -: 8] <= su_data;
        end
      end
    end
    assign tbl_o[e] = ent_q;
  end
endmodule

// File: rtl/fd_da_capture.sv
module fd_da_capture
  import fd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic          rx_sof,
  input  logic [7:0]    rx_data,
  output logic [AW-1:0] da_full_o,
  output logic          da_done_o,
  output logic          da_mcast_o
);
  localparam logic [IDX_W-1:0] IDLE = IDX_W'(ADDR_BYTES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ADDR_BYTES - 1);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_now;
  logic [AW-9:0]    hold_q;
  logic             take;

  assign idx_now    = rx_sof ? '0 : idx_q;
  assign take       = rx_valid && (idx_now < IDLE);
  assign da_done_o  = take && (idx_now == LAST);
  assign da_full_o  = {hold_q, rx_data};
  assign da_mcast_o = is_group(hold_q[AW-9 -: 8]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= IDLE;
      hold_q <= '0;
    end else if (take) begin
      idx_q <= idx_now + 1'b1;
      for (int k = 0; k < ADDR_BYTES - 1; k++) begin
        if (idx_now == IDX_W'(k))
          hold_q[AW-9-8*k -: 8] <= rx_data;
      end
    end
  end
endmodule

// File: rtl/fd_match.sv
module fd_match
  import fd_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_ENT-1:0][AW-1:0] tbl,
  input  logic                       tbl_active,
  input  mode_t                      mode,
  input  logic [AW-1:0]              da_full,
  input  logic                       da_done,
  input  logic                       da_mcast,
  output logic                       dec_valid_o,
  output logic                       dec_accept_o
);
  logic [NUM_ENT-1:0] hit;
  logic               accept_now;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_cmp
    assign hit[e] = (tbl[e] == da_full);
  end

  assign accept_now = mode.promisc
                    | (mode.allmulti & da_mcast)
                    | (tbl_active & (|hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_o  <= 1'b0;
      dec_accept_o <= 1'b0;
    end else begin
      dec_valid_o  <= da_done;
      dec_accept_o <= da_done & accept_now;
    end
  end
endmodule

// File: rtl/dest_filter.sv
module dest_filter
  import fd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       su_valid,
  input  logic [7:0] su_data,
  input  logic       su_last,
  output logic       su_ack,
  input  logic       rx_valid,
  input  logic       rx_sof,
  input  logic [7:0] rx_data,
  output logic       dec_valid,
  output logic       dec_accept
);
  logic [NUM_ENT-1:0][AW-1:0] tbl;
  logic                       tbl_active;
  mode_t                      mode;
  logic                       mode_allmulti;
  logic                       mode_promisc;
  logic [AW-1:0]              da_full;
  logic                       da_done;
  logic                       da_mcast;

  assign mode_allmulti = mode.allmulti;
  assign mode_promisc  = mode.promisc;

  fd_setup_loader u_load (
    .clk          (clk),
    .rst_n        (rst_n),
    .su_valid     (su_valid),
    .su_data      (su_data),
    .su_last      (su_last),
    .tbl_o        (tbl),
    .tbl_active_o (tbl_active),
    .mode_o       (mode),
    .su_ack_o     (su_ack)
  );

  fd_da_capture u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_sof     (rx_sof),
    .rx_data    (rx_data),
    .da_full_o  (da_full),
    .da_done_o  (da_done),
    .da_mcast_o (da_mcast)
  );

  fd_match u_match (
    .clk          (clk),
    .rst_n        (rst_n),
    .tbl          (tbl),
    .tbl_active   (tbl_active),
    .mode         (mode),
    .da_full      (da_full),
    .da_done      (da_done),
    .da_mcast     (da_mcast),
    .dec_valid_o  (dec_valid),
    .dec_accept_o (dec_accept)
  );
endmodule

// File: rtl/fd_checker.sv
module fd_checker (
  input logic clk,
  input logic rst_n,
  input logic su_valid,
  input logic su_last,
  input logic su_ack,
  input logic dec_valid,
  input logic dec_accept,
  input logic da_done,
  input logic da_mcast,
  input logic tbl_active,
  input logic mode_allmulti,
  input logic mode_promisc
);
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    su_ack |=> !su_ack); // R2
  AST_ACK_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    su_ack |-> $past(su_valid && su_last)); // R2
  AST_MODE_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !su_ack |-> $stable({mode_allmulti, mode_promisc})); // R3
  AST_DEC_AFTER_SIXTH: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(da_done)); // R4
  AST_SIXTH_GIVES_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    da_done |=> dec_valid); // R4
  AST_MCAST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(mode_allmulti && da_mcast)) |-> dec_accept); // R7
  AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(mode_promisc)) |-> dec_accept); // R8
  AST_EMPTY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(!tbl_active && !mode_allmulti && !mode_promisc)) |-> !dec_accept); // R9
endmodule

bind dest_filter fd_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .su_valid      (su_valid),
  .su_last       (su_last),
  .su_ack        (su_ack),
  .dec_valid     (dec_valid),
  .dec_accept    (dec_accept),
  .da_done       (da_done),
  .da_mcast      (da_mcast),
  .tbl_active    (tbl_active),
  .mode_allmulti (mode_allmulti),
  .mode_promisc  (mode_promisc)
);

// File: tb/tb_dest_filter.sv
`timescale 1ns/1ps
module tb_dest_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic su_valid = 1'b0, su_last = 1'b0, rx_valid = 1'b0, rx_sof = 1'b0;
  logic [7:0] su_data = '0, rx_data = '0;
  logic su_ack, dec_valid, dec_accept;
  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dest_filter dut (
    .clk(clk), .rst_n(rst_n), .su_valid(su_valid), .su_data(su_data),
    .su_last(su_last), .su_ack(su_ack), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_data(rx_data), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  // {requirement number, expected accept, destination with byte 0 in the top bits}
  localparam logic [52:0] VECS [8] = '{
    {4'd5,  1'b1, 48'h021122334050},   // R5 entry 0
    {4'd1,  1'b1, 48'h021122334656},   // R1 entry 6, last column of half 0
    {4'd1,  1'b1, 48'h021122334757},   // R1 entry 7, first column of half 1
    {4'd1,  1'b1, 48'h021122334D5D},   // R1 entry 13
    {4'd5,  1'b0, 48'h021122334556},   // R5 one byte off entry 5
    {4'd6,  1'b0, 48'hFFFFFFFFFFFF},   // R6 broadcast not loaded
    {4'd7,  1'b0, 48'h031122334050},   // R7 group address, mode off
    {4'd10, 1'b0, 48'h404142434445}    // R10 column-0 junk
  };

  function automatic string req_name(input logic [3:0] id);
    case (id)
      4'd1:    return "R1";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      default: return "R10";
    endcase
  endfunction

  // Setup byte i from the R1 layout; bc puts broadcast into entry 13.
  function automatic logic [7:0] setup_byte(input int i, input bit bc);
    int row, col, k, e;
    row = i / 8; col = i % 8; k = row % 8;
    if (col == 0) return 8'(8'h40 + row);
    if (k >= 6) return 8'h77;
    e = (row / 8) * 7 + col - 1;
    if (bc && e == 13) return 8'hFF;
    case (k)
      0: return 8'h02;
      1: return 8'h11;
      2: return 8'h22;
      3: return 8'h33;
      4: return 8'(8'h40 + e);
      default: return 8'(8'h50 + e);
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic send_setup(input int len, input bit bc, input string req);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      su_valid = 1'b1;
      su_data  = (i < 128) ? setup_byte(i, bc) : 8'h00;
      su_last  = (i == len - 1);
    end
    @(negedge clk);
    su_valid = 1'b0; su_last = 1'b0;
    check(su_ack == (len >= 128), req, 48'(su_ack), 48'(len >= 128));
    @(negedge clk);
    check(su_ack == 1'b0, "R2", 48'(su_ack), 48'd0);
  endtask

  task automatic send_da(input logic [47:0] da);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = (k == 0);
      rx_data  = da[47-8*k -: 8];
    end
  endtask

  task automatic probe(input logic [47:0] da, input bit exp, input string req);
    send_da(da);
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
    check(dec_valid && dec_accept == exp, req, 48'({dec_valid, dec_accept}), 48'({1'b1, exp}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!su_ack && !dec_valid && !dec_accept, "R9", 48'({su_ack, dec_valid, dec_accept}), 48'd0);
    probe(48'h000000000000, 1'b0, "R9");
    probe(48'h021122334050, 1'b0, "R9");

    send_setup(128, 1'b0, "R2");
    for (int v = 0; v < 8; v++)
      probe(VECS[v][47:0], VECS[v][48], req_name(VECS[v][52:49]));

    // R4: later bytes give no second decision; sof restarts capture
    send_da(48'h021122334050);
    @(negedge clk);
    rx_sof = 1'b0; rx_data = 8'h99;
    check(dec_valid == 1'b1, "R4", 48'(dec_valid), 48'd1);
    @(negedge clk);
    check(dec_valid == 1'b0, "R4", 48'(dec_valid), 48'd0);
    rx_valid = 1'b0;
    @(negedge clk);
    check(dec_valid == 1'b0, "R4", 48'(dec_valid), 48'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (k == 0); rx_data = 8'hEE;
    end
    probe(48'h021122334151, 1'b1, "R4");

    // R3/R7: all-multicast via length 129
    send_setup(129, 1'b0, "R3");
    probe(48'h03AABBCCDDEE, 1'b1, "R7");
    probe(48'h02AABBCCDDEE, 1'b0, "R7");
    send_setup(100, 1'b0, "R3");
    probe(48'h01AABBCCDDEE, 1'b1, "R3");

    // R8: promiscuous via length 130
    send_setup(130, 1'b0, "R8");
    probe(48'h02DEADBEEF00, 1'b1, "R8");
    probe(48'h031234567890, 1'b1, "R8");

    // R3: plain length clears modes
    send_setup(128, 1'b0, "R3");
    probe(48'h03AABBCCDDEE, 1'b0, "R3");
    probe(48'h02DEADBEEF00, 1'b0, "R3");

    // R6: broadcast loaded into entry 13
    send_setup(128, 1'b1, "R6");
    probe(48'hFFFFFFFFFFFF, 1'b1, "R6");
    probe(48'h021122334D5D, 1'b0, "R6");

    finish_run();
  end
endmodule